// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar in seven packed-BCD byte registers: seconds, minutes, hours, date, month, weekday and a two-digit year. A free-running prescaler divides the reference clock by 2^DIV_W, which is 32768 by default, so a 32.768 kHz reference gives one advance per second. Each advance carries through seconds, minutes, hours, day, month and year. The month length follows the calendar, and February gains its 29th day in leap years.

The hours register can hold either a 24-hour value or a 12-hour value with a PM flag, and the mode bit lives in the register itself. Bit 7 of the seconds register is a halt flag. While it is set, nothing counts and the prescaler is held at zero. A byte-wide load port lets a surrounding register bank overwrite any one field per cycle, and the written value wins over an advance that falls on the same edge.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, weekday 0x01 and year 0x00.
- R2: Every field counts in packed BCD. Seconds and minutes run 00 to 59, and each wrap from 59 to 00 carries into the next field.
- R3: While seconds bit 7 is 1, no field advances and the prescaler is held. When a load clears the bit, the first advance follows 2^DIV_W cycles after that load edge.
- R4: While running, the fields advance exactly once every 2^DIV_W clock cycles. The first advance after reset release lands on the 2^DIV_W-th rising edge.
- R5: With hours bit 7 = 0 (24-hour mode), bits 5:0 hold BCD 00 to 23. A wrap from 23 to 00 carries one day.
- R6: With hours bit 7 = 1 (12-hour mode), bits 4:0 hold BCD 12, 01 … 11 and bit 5 is PM. The step from 11 to 12 inverts PM, the step from 12 to 01 keeps it, and the step from 11 PM to 12 AM carries one day.
- R7: On each day carry, the weekday advances from 1 to 7 and wraps from 7 to 1.
- R8: On a day carry, the date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 or 29 in month 02. A year is a leap year when its BCD value is divisible by 4. A month wrap from 12 to 01 increments the year, and 99 wraps to 00.
- R9: A load with ld_we = 1 writes ld_data to the field selected by ld_addr (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year), visible after the next rising edge. Address 7 changes nothing, and hours bit 6 always reads 0.
- R10: A loaded field takes the load value even on an advance edge. The other fields advance that edge using carries computed from the pre-load values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (32.768 kHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Load strobe for one field |
| ld_addr | input | 3 | Field select for the load |
| ld_data | input | 8 | Packed-BCD value to load |
| sec_o | output | 8 | Halt flag (bit 7) and seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Mode bit, PM or tens-20 bit, hours |
| date_o | output | 8 | Date of month |
| month_o | output | 8 | Month |
| wday_o | output | 8 | Weekday 1 to 7 |
| year_o | output | 8 | Two-digit year |

## Verification
A load is visible after the rising edge that captures it. An advance occurs on the edge 2^DIV_W cycles after reset release, after a restart load, or after the previous advance. The bench drives on falling edges and counts rising edges from those reference edges, so every comparison falls on the falling edge that follows the edge where a change is due. Around each restart it samples both one edge before and on the expected advance edge. A priority load is placed exactly on an advance edge by waiting 2^DIV_W - 1 edges.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;

  // Packed-BCD increment of a value whose units digit is 0..9.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Last date of a month, in BCD. Divisibility by 4 is taken from the digits:
  // an even tens digit needs units 0/4/8, an odd one needs units 2/6.
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[1:0] == 2'b10) : (yr[1:0] == 2'b00);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Next hours byte, with bit 8 = day carry. Bit 6 of the result is always 0.
  function automatic logic [8:0] hour_step(input logic [7:0] h);
    logic [7:0] inc;
    logic [8:0] r;
    if (!h[7]) begin
      inc = bcd_inc({2'b00, h[5:0]});
      r   = (h[5:0] == 6'h23) ? {1'b1, 8'h00} : {1'b0, inc};
    end else begin
      inc = bcd_inc({3'b000, h[4:0]});
      case (h[4:0])
        5'h12:   r = {1'b0, 2'b10, h[5], 5'h01};
        5'h11:   r = {h[5], 2'b10, ~h[5], 5'h12};
        default: r = {1'b0, 2'b10, h[5], inc[4:0]};
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic tick
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (halt) cnt <= '0;
    else           cnt <= cnt + ONE;
  end

  assign tick = !halt && (&cnt);

  // Ticks are never back to back (period is at least 2 cycles).
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/cal_time_of_day.sv
module cal_time_of_day
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       halt,
  output logic       day_carry
);
  logic       sec_wrap;
  logic       min_wrap;
  logic [8:0] hstep;

  assign sec_wrap  = tick && (sec_q[6:0] == 7'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign hstep     = hour_step(hour_q);
  assign day_carry = min_wrap && hstep[8];
  assign halt      = sec_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (ld_sel[0])    sec_q <= ld_data;
      else if (tick)    sec_q <= sec_wrap ? {sec_q[7], 7'h00}
                                          : (bcd_inc({1'b0, sec_q[6:0]}) | {sec_q[7], 7'h00});
      if (ld_sel[1])     min_q <= ld_data;
      else if (sec_wrap) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (ld_sel[2])     hour_q <= ld_data & 8'hBF;
      else if (min_wrap) hour_q <= hstep[7:0];
    end
  end

  // Seconds wrap to zero and keep the halt bit.
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !ld_sel[0]) |=> (sec_q[6:0] == 7'h00));

  // 11 -> 12 in 12-hour mode inverts the PM flag.
  p_pm_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !ld_sel[2] && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])) && (hour_q[4:0] == 5'h12));

  // 24-hour mode never leaves 00..23.
  p_hour24_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !ld_sel[2] && !hour_q[7] && hour_q[5:0] == 6'h23) |=> (hour_q == 8'h00));

endmodule

// File: rtl/cal_date.sv
module cal_date
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic [3:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] wday_q,
  output logic [7:0] year_q
);
  logic date_wrap;
  logic month_wrap;

  assign date_wrap  = day_carry && (date_q == month_len(month_q, year_q));
  assign month_wrap = date_wrap && (month_q == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      wday_q  <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (ld_sel[0])      date_q <= ld_data;
      else if (day_carry) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
      if (ld_sel[1])      month_q <= ld_data;
      else if (date_wrap) month_q <= month_wrap ? 8'h01 : bcd_inc(month_q);
      if (ld_sel[2])      wday_q <= ld_data;
      else if (day_carry) wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'd1;
      if (ld_sel[3])       year_q <= ld_data;
      else if (month_wrap) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  // Month end returns the date to 01.
  p_month_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !ld_sel[0]) |=> (date_q == 8'h01));

  // Weekday wraps from 7 to 1.
  p_wday_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !ld_sel[2] && wday_q == 8'h07) |=> (wday_q == 8'h01));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import bcd_cal_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_we,
  input  logic [2:0] ld_addr,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] wday_o,
  output logic [7:0] year_o
);
  localparam int TOD_FIELDS = 3;

  logic [NUM_FIELDS-1:0] ld_sel;
  logic                  tick;
  logic                  halt;
  logic                  day_carry;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign ld_sel[i] = ld_we && (ld_addr == 3'(i));
  end

  cal_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick)
  );

  cal_time_of_day u_tod (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_sel(ld_sel[TOD_FIELDS-1:0]), .ld_data(ld_data),
    .sec_q(sec_o), .min_q(min_o), .hour_q(hour_o),
    .halt(halt), .day_carry(day_carry)
  );

  cal_date u_date (
    .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
    .ld_sel(ld_sel[NUM_FIELDS-1:TOD_FIELDS]), .ld_data(ld_data),
    .date_q(date_o), .month_q(month_o), .wday_q(wday_o), .year_q(year_o)
  );

  // Halted and not loaded: every field holds.
  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld_we)
      |=> $stable({sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o}));

  // A minutes load wins over any carry on the same edge.
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && ld_addr == 3'd1) |=> (min_o == $past(ld_data)));

endmodule

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
  localparam int DIV_W = 2;
  localparam int DIV   = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_we = 1'b0;
  logic [2:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;

  always #4 clk = ~clk;

  bcd_calendar_clock #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .wday_o(wday_o), .year_o(year_o)
  );

  int n_vec = 0, n_bad = 0;
  int m_sec, m_min, m_hr, m_date, m_mon, m_wday, m_year;
  bit m_12, m_halt;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input bit twelve);
    int h12;
    if (!twelve) return to_bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return 8'h80 | ((h >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction

  function automatic logic [55:0] exp_vec();
    return {(m_halt ? 8'h80 : 8'h00) | to_bcd(m_sec), to_bcd(m_min), enc_hour(m_hr, m_12),
            to_bcd(m_date), to_bcd(m_mon), to_bcd(m_wday), to_bcd(m_year)};
  endfunction

  task automatic model_tick();
    if (m_halt) return;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wday = (m_wday == 7) ? 1 : m_wday + 1;
          m_date++;
          if (m_date > mlen(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag);
    logic [55:0] got, exp;
    got = {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};
    exp = exp_vec();
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the load edge.
  task automatic ld(input logic [2:0] a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic set_time(input int h, input bit twelve, input int mi, input int s,
                          input int dt, input int mo, input int wd, input int y);
    ld(3'd0, 8'h80);
    ld(3'd1, to_bcd(mi));
    ld(3'd2, enc_hour(h, twelve));
    ld(3'd3, to_bcd(dt));
    ld(3'd4, to_bcd(mo));
    ld(3'd5, to_bcd(wd));
    ld(3'd6, to_bcd(y));
    ld(3'd0, to_bcd(s));
    m_hr = h; m_12 = twelve; m_min = mi; m_sec = s; m_date = dt;
    m_mon = mo; m_wday = wd; m_year = y; m_halt = 1'b0;
  endtask

  task automatic tick_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      repeat (DIV) @(posedge clk);
      @(negedge clk);
      model_tick();
      check(tag);
    end
  endtask

  task automatic period_check(input string tag);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    check({tag, " hold before advance"});
    @(posedge clk);
    @(negedge clk);
    model_tick();
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sec = 0; m_min = 0; m_hr = 0; m_12 = 0; m_halt = 0;
    m_date = 1; m_mon = 1; m_wday = 1; m_year = 0;
    check("R1 reset state");
    period_check("R4 first advance after reset");
    tick_check(5, "R4 steady period");

    // R9: field map, hours bit 6 masked, address 7 inert (while halted).
    set_time(7, 0, 30, 20, 10, 3, 2, 45);
    ld(3'd0, 8'h80 | to_bcd(20)); m_halt = 1'b1;
    check("R9 load map");
    ld(3'd2, 8'h52); m_hr = 12;
    check("R9 hours bit6 reads 0");
    ld(3'd7, 8'h33);
    check("R9 address 7 ignored");

    // R3: halt freezes, restart advances one full period later.
    repeat (3 * DIV) @(posedge clk);
    @(negedge clk);
    check("R3 halted fields frozen");
    ld(3'd0, to_bcd(20)); m_halt = 1'b0;
    period_check("R3 restart");

    // R10: load on an advance edge.
    set_time(5, 0, 10, 59, 10, 3, 2, 45);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    ld(3'd1, 8'h42);
    model_tick(); m_min = 42;
    check("R10 minutes load beats carry");
    set_time(5, 0, 59, 59, 10, 3, 2, 45);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    ld(3'd1, 8'h20);
    model_tick(); m_min = 20;
    check("R10 other fields use pre-load carry");
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    ld(3'd0, 8'h05);
    m_sec = 5;
    check("R10 seconds load beats increment");

    // R5/R6: every hour in both modes across the hour boundary.
    for (int tw = 0; tw < 2; tw++)
      for (int h = 0; h < 24; h++) begin
        set_time(h, bit'(tw), 59, 59, 15, 6, 4, 21);
        tick_check(2, tw ? "R6 12-hour step" : "R5 24-hour step");
      end

    // R7/R8: last day of every month in every year.
    for (int y = 0; y < 100; y++)
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(23, 0, 59, 59, mlen(mo, y), mo, (y + mo) % 7 + 1, y);
        tick_check(1, "R8 month end / R7 weekday");
      end
    for (int y = 0; y < 100; y++) begin
      set_time(23, 0, 59, 59, 28, 2, 7, y);
      tick_check(1, "R8 february 28");
    end

    // R2/R6/R8: free run across midnight and year end in 12-hour mode.
    set_time(22, 1, 59, 50, 31, 12, 7, 99);
    tick_check(3700, "R2 free run");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule